// File: doc/BRIEF.md
# Gated Clock Frequency Counter

This block measures the rate of one clock picked from a bank of up to 128 inputs. Software writes a control word that holds a gate length, an enable, a run strobe and a source index. The block then opens a gate window timed in microseconds from a prescaled system clock, counts rising edges of the chosen clock inside that window and stores the count in a result word. The frequency in hertz is the count times one million divided by the window length in microseconds, and software does that division.

Edges are counted in the measured clock's own domain. The gate crosses into that domain through a two-flop synchroniser. The end of counting comes back to the system domain as a toggle, and only then is the count copied into the result register. A busy flag is set from the start strobe until that copy is made. In continuous mode the next window opens in the same cycle as the copy, and busy stays set. The counter stops at the all-ones value, so software can tell an overflow from a valid reading and reject it.

Top module: `clkmeter_top`

## Requirements
- R1: After reset the control word (word index 1) and the result word (word index 3) both read 0, and busy is 0.
- R2: The control word reads back the gate field in bits 15:0, enable in bit 16, continuous in bit 17, interrupt enable in bit 18 and the source index in bits 26:20. The run strobe in bit 19 always reads 0, and busy is bit 31.
- R3: A control write with run (bit 19) and enable (bit 16) both 1, made while idle, sets busy on the next clock. Busy clears once the window has closed and the result word holds the new count.
- R4: The gate stays open for exactly (field + 1) × TICK_DIV system cycles, that is (field + 1) microseconds. The result is the number of rising edges of the selected clock inside that window.
- R5: Bits 26:20 select input index 0 to 127, and the count always comes from the selected input.
- R6: The count saturates at 0xFFFF and does not wrap.
- R7: A control write with run = 1 and enable = 0 starts nothing: busy stays 0 and the result word is unchanged.
- R8: A control write with enable = 0 while busy ends the measurement: busy reads 0 on the next clock and the result word is unchanged.
- R9: With continuous (bit 17) set, busy stays 1 across windows and the result word is refreshed after each one. Clearing continuous lets the current window finish, after which busy clears.
- R10: The edge counter restarts from zero at the start of every window, so one count never carries into the next.
- R11: A run written while busy is ignored. The window in progress keeps the gate length and source it started with.
- R12: Word indices 0 and 2 read 0, and bits 31:16 of the result word read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock; the gate timer, registers and result live here |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| src_clks | input | NUM_SRC | Bank of clocks that can be measured |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 2 | Word index (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at bus_addr, combinational |

## Verification
A wrong gate timer or prescaler state shows up at once as a result that is off by a whole multiple of the edges per microsecond. It appears in the first result after busy clears, which is a few microseconds after the run. A stuck handshake toggle or a wrong synchroniser stage shows up as busy never clearing, or as a result that is one count off at a window boundary. Sweeping every ratio between clocks and several gate lengths makes those errors show as exact mismatches. A counter that wraps or fails to restart gives a small or an accumulated value on the next read of the result.

// File: rtl/clkmeter_pkg.sv
package clkmeter_pkg;

  // Field widths of the control and result words.
  localparam int unsigned DUR_W = 16;
  localparam int unsigned SRC_W = 7;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned SRC_SPACE = 1 << SRC_W;

  // Bit positions inside the control word.
  localparam int unsigned EN_BIT   = 16;
  localparam int unsigned CONT_BIT = 17;
  localparam int unsigned IRQ_BIT  = 18;
  localparam int unsigned RUN_BIT  = 19;
  localparam int unsigned SRC_LSB  = 20;
  localparam int unsigned BUSY_BIT = 31;

  // Word indices on the register port.
  localparam logic [1:0] CTRL_IDX = 2'd1;
  localparam logic [1:0] RES_IDX  = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_OPEN  = 2'd2,
    ST_DRAIN = 2'd3
  } win_state_e;

  // Increment that stops at all-ones.
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + CNT_W'(1);
  endfunction

  // Number of system cycles the gate stays open for a given field value.
  function automatic logic [31:0] win_cycles(input logic [DUR_W-1:0] field,
                                             input int unsigned div);
    return (32'(field) + 32'd1) * div;
  endfunction

endpackage

// File: rtl/clkmeter_srcsel.sv
module clkmeter_srcsel
  import clkmeter_pkg::*;
#(
  parameter int unsigned NUM_SRC = 128
) (
  input  logic [NUM_SRC-1:0] src_clks,
  input  logic [SRC_W-1:0]   sel,
  output logic               mclk
);

  logic [SRC_SPACE-1:0] padded;

  // Indices past the populated inputs read as a quiet low level.
  for (genvar i = 0; i < SRC_SPACE; i++) begin : g_pad
    if (i < NUM_SRC) begin : g_live
      assign padded[i] = src_clks[i];
    end else begin : g_tie
      assign padded[i] = 1'b0;
    end
  end

  assign mclk = padded[sel];

endmodule

// File: rtl/clkmeter_edgecount.sv
module clkmeter_edgecount
  import clkmeter_pkg::*;
(
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             gate_i,
  output logic [CNT_W-1:0] count_o,
  output logic             done_tgl_o
);

  logic gate_s1, gate_s2, gate_s3;
  logic [CNT_W-1:0] cnt_q;
  logic tgl_q;

  // Window edges as seen in the measured domain.
  logic win_rise, win_fall;
  assign win_rise = gate_s2 & ~gate_s3;
  assign win_fall = gate_s3 & ~gate_s2;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      gate_s1 <= 1'b0;
      gate_s2 <= 1'b0;
      gate_s3 <= 1'b0;
      cnt_q   <= '0;
      tgl_q   <= 1'b0;
    end else begin
      gate_s1 <= gate_i;
      gate_s2 <= gate_s1;
      gate_s3 <= gate_s2;
      if (win_rise)     cnt_q <= CNT_W'(1);
      else if (gate_s2) cnt_q <= sat_inc(cnt_q);
      if (win_fall)     tgl_q <= ~tgl_q;
    end
  end

  assign count_o    = cnt_q;
  assign done_tgl_o = tgl_q;

  // R6
  sat_hold_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    ((&cnt_q) && gate_s2 && gate_s3) |=> (&cnt_q));

  // R10
  restart_zero_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    win_rise |=> (cnt_q == CNT_W'(1)));

endmodule

// File: rtl/clkmeter_window.sv
module clkmeter_window
  import clkmeter_pkg::*;
#(
  parameter int unsigned TICK_DIV = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             cont_i,
  input  logic [DUR_W-1:0] new_dur_i,
  input  logic [SRC_W-1:0] new_src_i,
  input  logic             done_tgl_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             gate_o,
  output logic             busy_o,
  output logic [SRC_W-1:0] sel_o,
  output logic [CNT_W-1:0] result_o
);

  localparam int unsigned PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  win_state_e       state_q;
  logic [PRE_W-1:0] pre_q;
  logic [DUR_W-1:0] us_q, dur_q;
  logic [SRC_W-1:0] sel_q;
  logic [CNT_W-1:0] result_q;
  logic             gate_q;
  logic             tg1, tg2, tg3;

  // Named internal events.
  logic us_tick, win_close, done_evt, capture;
  assign us_tick   = (state_q == ST_OPEN) && (pre_q == PRE_LAST);
  assign win_close = us_tick && (us_q == dur_q);
  assign done_evt  = tg2 ^ tg3;
  assign capture   = (state_q == ST_DRAIN) && done_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pre_q    <= '0;
      us_q     <= '0;
      dur_q    <= '0;
      sel_q    <= '0;
      result_q <= '0;
      gate_q   <= 1'b0;
      tg1      <= 1'b0;
      tg2      <= 1'b0;
      tg3      <= 1'b0;
    end else begin
      tg1 <= done_tgl_i;
      tg2 <= tg1;
      tg3 <= tg2;
      if (abort_i) begin
        state_q <= ST_IDLE;
        gate_q  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (start_i) begin
              state_q <= ST_ARM;
              dur_q   <= new_dur_i;
              sel_q   <= new_src_i;
            end
          end
          ST_ARM: begin
            state_q <= ST_OPEN;
            gate_q  <= 1'b1;
            pre_q   <= '0;
            us_q    <= '0;
          end
          ST_OPEN: begin
            if (us_tick) begin
              pre_q <= '0;
              if (win_close) begin
                gate_q  <= 1'b0;
                state_q <= ST_DRAIN;
              end else begin
                us_q <= us_q + DUR_W'(1);
              end
            end else begin
              pre_q <= pre_q + PRE_W'(1);
            end
          end
          ST_DRAIN: begin
            if (capture) begin
              result_q <= count_i;
              if (cont_i) begin
                state_q <= ST_OPEN;
                gate_q  <= 1'b1;
                pre_q   <= '0;
                us_q    <= '0;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign gate_o   = gate_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign sel_o    = sel_q;
  assign result_o = result_q;

  // Cycle count of the open gate, kept only for the window check.
  logic [31:0] open_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      open_cnt <= '0;
    else if (gate_q) open_cnt <= open_cnt + 32'd1;
    else             open_cnt <= '0;
  end

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !abort_i && state_q == ST_IDLE) |=> busy_o);

  // R4
  window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_close && !abort_i) |-> (open_cnt + 32'd1 == win_cycles(dur_q, TICK_DIV)));

  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !busy_o);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_DRAIN) |=> $stable(result_q));

  // R9
  cont_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && cont_i && !abort_i) |=> (busy_o && gate_o));

  // R11
  sel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(sel_q));

endmodule

// File: rtl/clkmeter_regs.sv
module clkmeter_regs
  import clkmeter_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  input  logic             busy_i,
  input  logic [CNT_W-1:0] result_i,
  output logic [31:0]      rdata,
  output logic             cont_o,
  output logic             start_o,
  output logic             abort_o,
  output logic [DUR_W-1:0] new_dur_o,
  output logic [SRC_W-1:0] new_src_o
);

  logic [DUR_W-1:0] dur_q;
  logic [SRC_W-1:0] src_q;
  logic             en_q, cont_q, irq_q;
  logic             ctrl_wr;

  assign ctrl_wr = wr_en && (addr == CTRL_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dur_q  <= '0;
      src_q  <= '0;
      en_q   <= 1'b0;
      cont_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (ctrl_wr) begin
      dur_q  <= wdata[DUR_W-1:0];
      src_q  <= wdata[SRC_LSB +: SRC_W];
      en_q   <= wdata[EN_BIT];
      cont_q <= wdata[CONT_BIT];
      irq_q  <= wdata[IRQ_BIT];
    end
  end

  assign start_o   = ctrl_wr && wdata[EN_BIT] && wdata[RUN_BIT];
  assign abort_o   = ctrl_wr && !wdata[EN_BIT];
  assign new_dur_o = wdata[DUR_W-1:0];
  assign new_src_o = wdata[SRC_LSB +: SRC_W];
  assign cont_o    = cont_q;

  always_comb begin
    rdata = '0;
    if (addr == CTRL_IDX) begin
      rdata[DUR_W-1:0]          = dur_q;
      rdata[EN_BIT]             = en_q;
      rdata[CONT_BIT]           = cont_q;
      rdata[IRQ_BIT]            = irq_q;
      rdata[SRC_LSB +: SRC_W]   = src_q;
      rdata[BUSY_BIT]           = busy_i;
    end else if (addr == RES_IDX) begin
      rdata[CNT_W-1:0] = result_i;
    end
  end

endmodule

// File: rtl/clkmeter_top.sv
module clkmeter_top
  import clkmeter_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 128,
  parameter int unsigned TICK_DIV = 50
) (
  input  logic               clk_sys,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_clks,
  input  logic               bus_wr,
  input  logic [1:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata
);

  logic             cont, start, abort, busy, gate, done_tgl, mclk;
  logic [DUR_W-1:0] new_dur;
  logic [SRC_W-1:0] new_src, sel;
  logic [CNT_W-1:0] count, result;

  clkmeter_regs u_regs (
    .clk       (clk_sys),
    .rst_n     (rst_n),
    .wr_en     (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .busy_i    (busy),
    .result_i  (result),
    .rdata     (bus_rdata),
    .cont_o    (cont),
    .start_o   (start),
    .abort_o   (abort),
    .new_dur_o (new_dur),
    .new_src_o (new_src)
  );

  clkmeter_window #(.TICK_DIV(TICK_DIV)) u_win (
    .clk        (clk_sys),
    .rst_n      (rst_n),
    .start_i    (start),
    .abort_i    (abort),
    .cont_i     (cont),
    .new_dur_i  (new_dur),
    .new_src_i  (new_src),
    .done_tgl_i (done_tgl),
    .count_i    (count),
    .gate_o     (gate),
    .busy_o     (busy),
    .sel_o      (sel),
    .result_o   (result)
  );

  clkmeter_srcsel #(.NUM_SRC(NUM_SRC)) u_sel (
    .src_clks (src_clks),
    .sel      (sel),
    .mclk     (mclk)
  );

  clkmeter_edgecount u_cnt (
    .mclk       (mclk),
    .rst_n      (rst_n),
    .gate_i     (gate),
    .count_o    (count),
    .done_tgl_o (done_tgl)
  );

  // R3
  gate_in_busy_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
    gate |-> busy);

endmodule

// File: tb/sim_clkmeter_top.sv
module sim_clkmeter_top;

  localparam int TD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic c0 = 1'b0, c1 = 1'b0, c2 = 1'b0, c3 = 1'b0;
  logic [127:0] srcs;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;

  assign srcs = {32{c3, c2, c1, c0}};

  clkmeter_top #(.NUM_SRC(128), .TICK_DIV(TD)) u0 (
    .clk_sys   (clk),
    .rst_n     (rst_n),
    .src_clks  (srcs),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  // 50 MHz system clock, rising edges at 10 + 20k ns.
  always #10 clk = ~clk;

  // Measured clocks: periods 10, 16, 40, 80 ns, rising at 3 + P*k.
  initial begin #3; forever begin c0 = 1'b1; #5;  c0 = 1'b0; #5;  end end
  initial begin #3; forever begin c1 = 1'b1; #8;  c1 = 1'b0; #8;  end end
  initial begin #3; forever begin c2 = 1'b1; #20; c2 = 1'b0; #20; end end
  initial begin #3; forever begin c3 = 1'b1; #40; c3 = 1'b0; #40; end end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl(input int field, input bit en, input bit cont,
                                       input bit run, input int src);
    return 32'(field & 16'hFFFF) | (32'(en) << 16) | (32'(cont) << 17) |
           (32'(run) << 19) | (32'(src & 7'h7F) << 20);
  endfunction

  // Edges of input src in a D-microsecond gate (1 us = TD*20 ns = 80 ns).
  function automatic int exp_count(input int src, input int d);
    int n;
    case (src % 4)
      0: n = 8 * d;
      1: n = 5 * d;
      2: n = 2 * d;
      default: n = d;
    endcase
    return (n > 65535) ? 65535 : n;
  endfunction

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle(input int limit, input string req);
    logic [31:0] v;
    int n = 0;
    bus_read(2'd1, v);
    while (v[31] && n < limit) begin
      @(negedge clk);
      bus_read(2'd1, v);
      n++;
    end
    if (v[31]) check(req, 32'd1, 32'd0);
  endtask

  task automatic measure(input int src, input int d, input string req);
    logic [31:0] v;
    bus_write(2'd1, ctrl(d - 1, 1'b1, 1'b0, 1'b1, src));
    bus_read(2'd1, v);
    check("R3 busy after run", 32'(v[31]), 32'd1);
    wait_idle(d * TD + 200, req);
    bus_read(2'd3, v);
    check(req, v, 32'(exp_count(src, d)));
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] prev;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(2'd1, v); check("R1 ctrl after reset", v, 32'd0);
    bus_read(2'd3, v); check("R1 result after reset", v, 32'd0);
    // R12 unused words
    bus_read(2'd0, v); check("R12 word 0", v, 32'd0);
    bus_read(2'd2, v); check("R12 word 2", v, 32'd0);

    // R2 readback of every field, run reads 0
    bus_write(2'd1, ctrl(16'h1234, 1'b0, 1'b1, 1'b1, 7'h55) | (32'd1 << 18));
    bus_read(2'd1, v);
    check("R2 field readback", v, 32'h0556_1234);
    bus_write(2'd1, 32'd0);
    bus_read(2'd1, v); check("R2 cleared", v, 32'd0);

    // R7 run without enable
    bus_write(2'd1, ctrl(9, 1'b0, 1'b0, 1'b1, 0));
    bus_read(2'd1, v); check("R7 busy stays low", 32'(v[31]), 32'd0);
    repeat (100) @(negedge clk);
    bus_read(2'd1, v); check("R7 still idle", 32'(v[31]), 32'd0);
    bus_read(2'd3, v); check("R7 result unchanged", v, 32'd0);

    // R4 / R5 sweep over sources and gate lengths
    foreach (v[i]) begin end
    for (int si = 0; si < 11; si++) begin
      int s;
      s = (si < 8) ? si : 117 + si;
      for (int di = 0; di < 4; di++) begin
        int d;
        d = (di == 3) ? 7 : di + 1;
        measure(s, d, $sformatf("R4 R5 src %0d dur %0d", s, d));
      end
    end

    // R10 restart from zero: long then short window
    measure(2, 20, "R10 long window");
    measure(2, 3, "R10 short window after long");

    // R11 run written while busy is ignored
    bus_write(2'd1, ctrl(9, 1'b1, 1'b0, 1'b1, 2));
    repeat (5) @(negedge clk);
    bus_write(2'd1, ctrl(49, 1'b1, 1'b0, 1'b1, 0));
    wait_idle(400, "R11 idle");
    bus_read(2'd3, v); check("R11 original window kept", v, 32'd20);

    // R8 abort
    bus_write(2'd1, ctrl(999, 1'b1, 1'b0, 1'b1, 1));
    repeat (20) @(negedge clk);
    bus_read(2'd1, v); check("R8 busy before abort", 32'(v[31]), 32'd1);
    bus_read(2'd3, prev);
    bus_write(2'd1, ctrl(0, 1'b0, 1'b0, 1'b0, 1));
    bus_read(2'd1, v); check("R8 busy cleared", 32'(v[31]), 32'd0);
    repeat (60) @(negedge clk);
    bus_read(2'd3, v); check("R8 result unchanged", v, prev);
    measure(2, 2, "R8 clean measurement after abort");

    // R9 continuous mode
    bus_write(2'd1, ctrl(14, 1'b1, 1'b1, 1'b1, 2));
    repeat (15 * TD + 40) @(negedge clk);
    bus_read(2'd1, v); check("R9 busy held", 32'(v[31]), 32'd1);
    bus_read(2'd3, v); check("R9 first result", v, 32'd30);
    repeat (200) @(negedge clk);
    bus_read(2'd1, v); check("R9 busy held later", 32'(v[31]), 32'd1);
    bus_write(2'd1, ctrl(14, 1'b1, 1'b0, 1'b0, 2));
    wait_idle(400, "R9 stops after clearing continuous");
    bus_read(2'd3, v); check("R9 last result", v, 32'd30);

    // R6 saturation boundary
    measure(0, 8191, "R6 just below saturation");
    measure(0, 8200, "R6 saturated");
    bus_read(2'd3, v); check("R12 result upper bits", 32'(v[31:16]), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule